// File: doc/BRIEF.md
# DRAM Warm-Up and CAS-Before-RAS Refresh Scheduler

This block owns the refresh duty of an asynchronous DRAM sitting beside an access controller on a shared 100 MHz clock. After reset it holds off for a fixed warm-up pause. It then runs a set number of dummy refresh cycles before it raises a ready flag that permits normal traffic. Every refresh is a CAS-before-RAS cycle: CAS falls first, so the DRAM takes the row from its own internal counter and the block never drives an address or data.

Once ready, an interval timer posts one refresh request per interval. The interval is chosen so that every row is covered evenly within the retention period. Requests collect in a saturating pending counter. The block starts a refresh only at a burst boundary, which the access controller signals with its idle input. It needs the controller's grant to do so, unless the counter is full; a full counter takes the bus at the next boundary without a grant. While the block owns the bus it drives RAS, CAS, WE and OE, and it raises an ownership flag that the surrounding logic uses to steer those pins. WE and OE stay high throughout, so the DRAM output stays in high impedance.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `ref_own` stays low for exactly `PAUSE_CYC` clock cycles. With `ctl_idle` high, the first owned cycle comes on the next cycle after that.
- R2: Before `mem_ready` rises, the block runs exactly `INIT_REF` refresh cycles. Each of them starts when `ctl_idle` is high and needs no grant.
- R3: In every refresh, `cas_n` is low for exactly `T_CSR` cycles before `ras_n` falls. `cas_n` stays low for as long as `ras_n` is low. `we_n` and `oe_n` are high in every cycle.
- R4: `ras_n` stays low for exactly `T_RAS` cycles. After `ras_n` rises, both strobes stay high for at least `T_RP` cycles before the next `cas_n` fall.
- R5: Once `mem_ready` is high, one refresh request is added every `REFI_CYC` cycles. The first is added `REFI_CYC` cycles after `mem_ready` rises.
- R6: After ready, a refresh starts only from a cycle in which `ctl_idle` is high. It also needs `bus_gnt` high or a full pending count. `ref_own` rises in the next cycle.
- R7: The pending count saturates at `MAX_PEND`, and any further request is dropped. At a full count, a refresh starts at the next idle cycle even without `bus_grant`.
- R8: While ready and not owning the bus, `bus_req` is high exactly when at least one refresh is pending. With grant and idle held high, pending refreshes run back to back until none remain.
- R9: In reset, the outputs are `mem_ready`=0, `bus_req`=0 and `ref_own`=0, with `ras_n`, `cas_n`, `we_n` and `oe_n` all 1. Once `mem_ready` has risen, it never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the access controller |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_idle | input | 1 | Access controller is at a burst boundary |
| bus_gnt | input | 1 | Access controller yields the DRAM bus |
| mem_ready | output | 1 | Warm-up complete; normal accesses allowed |
| bus_req | output | 1 | Refresh wanted or bus in use by refresh |
| ref_own | output | 1 | Block is driving the DRAM control strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |

## Verification
The scheduler is exercised four ways:
- Idle held high with the grant withheld. Refreshes can then start only through saturation, which separates the forced path from the granted one.
- Grant held high with idle held low. This shows that the burst boundary gates even a granted refresh.
- Both inputs held high. This drains the backlog and measures the steady interval rate.
- A seeded random mix of idle and grant. A cycle-by-cycle model of the pending count is then compared against `bus_req`, which separates correct counting, saturation and draining from miscounted or dropped requests.

Every refresh edge is also timed against the strobe-ordering and width rules.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int PAUSE_CYC = 20000,
  parameter int INIT_REF  = 8,
  parameter int REFI_CYC  = 1560,
  parameter int MAX_PEND  = 8,
  parameter int T_CSR     = 1,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_idle,
  input  logic bus_gnt,
  output logic mem_ready,
  output logic bus_req,
  output logic ref_own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic oe_n
);
  localparam int M1   = (PAUSE_CYC > T_RAS) ? PAUSE_CYC : T_RAS;
  localparam int M2   = (T_RP > T_CSR) ? T_RP : T_CSR;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(REFI_CYC + 1);
  localparam int PW   = $clog2(MAX_PEND + 1);
  localparam int IW   = $clog2(INIT_REF + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_CSR, S_RAS, S_PRE} st_t;

  st_t           st;
  logic [CW-1:0] tmr;
  logic [RW-1:0] iv;
  logic [PW-1:0] pend;
  logic [IW-1:0] inits;
  logic          tick, go, full, inc, dec;

  assign full = (pend == PW'(MAX_PEND));
  assign tick = mem_ready && (iv == RW'(REFI_CYC - 1));
  assign go   = (st == S_IDLE) && ctl_idle &&
                (!mem_ready || ((pend != '0) && (bus_gnt || full)));
  assign dec  = go && mem_ready;
  assign inc  = tick && (!full || dec);

  assign ref_own = (st == S_CSR) || (st == S_RAS) || (st == S_PRE);
  assign bus_req = ref_own || ((st == S_IDLE) && (!mem_ready || pend != '0));
  assign ras_n   = (st != S_RAS);
  assign cas_n   = !((st == S_CSR) || (st == S_RAS));
  assign we_n    = 1'b1;
  assign oe_n    = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PAUSE;
      tmr       <= CW'(PAUSE_CYC - 1);
      inits     <= '0;
      mem_ready <= 1'b0;
    end else begin
      unique case (st)
        S_PAUSE: begin
          if (tmr == '0) st <= S_IDLE;
          else tmr <= tmr - 1'b1;
        end
        S_IDLE: begin
          if (go) begin
            st  <= S_CSR;
            tmr <= CW'(T_CSR - 1);
          end
        end
        S_CSR: begin
          if (tmr == '0) begin
            st  <= S_RAS;
            tmr <= CW'(T_RAS - 1);
          end else tmr <= tmr - 1'b1;
        end
        S_RAS: begin
          if (tmr == '0) begin
            st  <= S_PRE;
            tmr <= CW'(T_RP - 1);
          end else tmr <= tmr - 1'b1;
        end
        S_PRE: begin
          if (tmr == '0) begin
            st <= S_IDLE;
            if (!mem_ready) begin
              inits <= inits + 1'b1;
              if (inits == IW'(INIT_REF - 1)) mem_ready <= 1'b1;
            end
          end else tmr <= tmr - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv   <= '0;
      pend <= '0;
    end else begin
      if (mem_ready) iv <= tick ? '0 : iv + 1'b1;
      pend <= pend + PW'(inc) - PW'(dec);
    end
  end
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int PAUSE_CYC = 20000
) (
  input logic clk,
  input logic rst_n,
  input logic ctl_idle,
  input logic bus_gnt,
  input logic mem_ready,
  input logic bus_req,
  input logic ref_own,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n
);
  localparam int KW = $clog2(PAUSE_CYC + 2);
  logic [KW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (since <= KW'(PAUSE_CYC)) since <= since + 1'b1;
  end

  p_pause_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since <= KW'(PAUSE_CYC)) |-> !ref_own);
  p_cas_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));
  p_cas_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (!cas_n && ref_own));
  p_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_n && oe_n);
  p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_own) |-> $past(ctl_idle));
  p_req_before_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_own) |-> $past(bus_req));
  p_ready_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> mem_ready);
  p_strobes_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_own |-> (ras_n && cas_n));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.PAUSE_CYC(PAUSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_idle(ctl_idle), .bus_gnt(bus_gnt),
  .mem_ready(mem_ready), .bus_req(bus_req), .ref_own(ref_own),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int PAUSE = 50, NINIT = 8, REFI = 100, MAXP = 8;
  localparam int TCSR = 1, TRAS = 5, TRP = 4;

  logic clk = 1'b0, rst_n = 1'b0, ctl_idle = 1'b1, bus_gnt = 1'b0;
  logic mem_ready, bus_req, ref_own, ras_n, cas_n, we_n, oe_n;

  always #2 clk = ~clk;

  dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INIT_REF(NINIT), .REFI_CYC(REFI),
    .MAX_PEND(MAXP), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_idle(ctl_idle), .bus_gnt(bus_gnt),
    .mem_ready(mem_ready), .bus_req(bus_req), .ref_own(ref_own),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pend_next(int p, bit tk, bit dc);
    return p + ((tk && (p != MAXP || dc)) ? 1 : 0) - (dc ? 1 : 0);
  endfunction

  int nsamp = 0, rs = 0, pend_m = 0, starts = 0, init_starts = 0, first_own = 0;
  int cas_lead = 0, ras_lo = 0, hi_run = 0, forced = 0;
  bit tick_next = 0, p_own = 0, p_ready = 0, p_ras = 1, p_cas = 1, seen_rise = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit rose, dc;
      nsamp++;
      rose = ref_own && !p_own;
      dc = rose && p_ready;
      if (dc) begin
        chk(ctl_idle && (bus_gnt || pend_m == MAXP) && pend_m != 0, "R6", pend_m, MAXP);
        if (!bus_gnt) begin
          forced++;
          chk(pend_m == MAXP, "R7", pend_m, MAXP);
        end
        starts++;
      end
      if (rose && !p_ready) begin
        init_starts++;
        if (first_own == 0) begin
          first_own = nsamp;
          chk(nsamp == PAUSE + 1, "R1", nsamp, PAUSE + 1);
        end
        chk(ctl_idle, "R2", ctl_idle, 1);
      end
      pend_m = pend_next(pend_m, tick_next, dc);
      if (mem_ready && !ref_own) chk(bus_req == (pend_m != 0), "R8", bus_req, pend_m != 0);
      if (mem_ready && !p_ready) chk(init_starts == NINIT, "R2", init_starts, NINIT);
      if (!mem_ready && p_ready) chk(0, "R9", 0, 1);
      tick_next = 0;
      if (mem_ready) begin
        rs++;
        tick_next = (rs % REFI == 0);
      end
      if (!we_n || !oe_n) chk(0, "R3", {we_n, oe_n}, 3);
      if (!ras_n && cas_n) chk(0, "R3", cas_n, 0);
      if (!ref_own && (!ras_n || !cas_n)) chk(0, "R9", {ras_n, cas_n}, 3);
      if (!cas_n && p_cas && seen_rise) chk(hi_run >= TRP, "R4", hi_run, TRP);
      if (!ras_n && p_ras) begin
        chk(cas_lead == TCSR, "R3", cas_lead, TCSR);
        ras_lo = 0;
      end
      if (ras_n && !p_ras) begin
        chk(ras_lo == TRAS, "R4", ras_lo, TRAS);
        hi_run = 0;
        seen_rise = 1;
      end
      if (!ras_n) ras_lo++;
      if (!cas_n && ras_n) cas_lead++; else cas_lead = 0;
      if (ras_n && cas_n) hi_run++;
      p_own = ref_own; p_ready = mem_ready; p_ras = ras_n; p_cas = cas_n;
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int s0, f0, w;
    void'($urandom(32'd20240611));
    step(4);
    // R9 reset state
    chk(!mem_ready && !bus_req && !ref_own, "R9", {mem_ready, bus_req, ref_own}, 0);
    chk(ras_n && cas_n && we_n && oe_n, "R9", {ras_n, cas_n, we_n, oe_n}, 15);
    rst_n = 1'b1;
    w = 0;
    while (!mem_ready && w < 5000) begin step(1); w++; end
    chk(mem_ready, "R2", mem_ready, 1);
    chk(first_own == PAUSE + 1, "R1", first_own, PAUSE + 1);
    // R7: idle high, no grant -> only forced starts
    bus_gnt = 1'b0; ctl_idle = 1'b1;
    f0 = forced;
    step(11 * REFI);
    chk(forced - f0 >= 2, "R7", forced - f0, 2);
    // R6: grant high, idle low -> nothing starts
    ctl_idle = 1'b0; bus_gnt = 1'b1;
    s0 = starts;
    step(3 * REFI);
    chk(starts == s0, "R6", starts - s0, 0);
    chk(bus_req, "R8", bus_req, 1);
    // R8: drain the saturated backlog
    ctl_idle = 1'b1;
    s0 = starts;
    w = 0;
    while ((bus_req || ref_own) && w < 2000) begin step(1); w++; end
    chk(starts - s0 >= MAXP && starts - s0 <= MAXP + 1, "R8", starts - s0, MAXP);
    chk(w <= (MAXP + 1) * (TCSR + TRAS + TRP + 1) + 2, "R8", w, (MAXP + 1) * (TCSR + TRAS + TRP + 1));
    // R5: steady rate with everything open
    s0 = starts;
    step(20 * REFI);
    chk(starts - s0 >= 19 && starts - s0 <= 21, "R5", starts - s0, 20);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      ctl_idle = ($urandom % 5) != 0;
      bus_gnt  = ($urandom % 3) != 0;
      if (i % 1500 < 40) ctl_idle = 1'b0;
      step(1);
    end
    ctl_idle = 1'b1; bus_gnt = 1'b1;
    step(3 * REFI);
    w = 0;
    while ((bus_req || ref_own) && w < 200) begin step(1); w++; end
    chk(!bus_req && pend_m == 0, "R8", pend_m, 0);
    chk(mem_ready, "R9", mem_ready, 1);
    finish_run();
  end
endmodule